// File: doc/BRIEF.md
# Asynchronous Memory Strobe-Timing Controller

This block turns 32-bit word read and write requests from an internal bus into access cycles on an external asynchronous memory or FIFO port. Every access walks through three phases: a setup phase, a strobe phase and a hold phase. Each phase length is programmed separately for reads and for writes, and is counted in interface clock cycles. A field programmed as N holds its phase for N+1 cycles.

When the external data bus is set to 16 bits, one word request becomes two halfword cycles issued back to back, lower half first. Between the two strobes there is only the hold phase of the first half and the setup phase of the second. A programmable turnaround gap is placed between accesses whose directions differ. A strobe-select mode narrows chip-select so that it is active only during the strobe phase.

Requests use a valid/ready pair. A new request can be taken during the last hold cycle of the current access, so accesses in the same direction run with no idle cycle between them. Configuration inputs are expected to stay constant while an access is in progress.

Top module: `async_strobe_ctrl`

## Requirements
- R1: After an access is accepted with no turnaround, the setup phase lasts (setup field + 1) cycles before the strobe begins, using the read or the write setup field according to the direction.
- R2: The read strobe lasts (read strobe field + 1) cycles with output-enable (active low) asserted only then. Write-enable (active low) is asserted only during a write strobe. The two enables are never active together. The data bus is driven during a write strobe and released during a read strobe.
- R3: The hold phase lasts (hold field + 1) cycles. In 16-bit mode the second strobe of a word starts exactly (strobe+1)+(hold+1)+(setup+1) cycles after the first one starts.
- R4: Read and write phase lengths come from separate fields: a write uses only the write setup, write strobe and write hold fields.
- R5: When an access has the opposite direction from the previous access since reset, (turnaround field + 1) idle cycles come before its setup phase. The first access after reset and accesses in the same direction get no gap.
- R6: With the bus-size select at 1 (16 bits), a word takes two accesses. The address LSB (halfword select) is 0 for the first and 1 for the second. Write data bits [15:0] then [31:16] appear on data-out bits [15:0], with the upper bits at 0. With the select at 0 (32 bits), a word takes one access with the LSB at 0 and all 32 data bits driven.
- R7: Read data is sampled from the bus on the last strobe cycle. In 16-bit mode the first half fills result bits [15:0] and the second fills [31:16], and in 16-bit mode the input bits [31:16] are ignored. The response valid pulses for one cycle, the cycle after the final hold cycle.
- R8: With strobe-select at 1, chip-select (active low) is active in exactly the strobe cycles. With it at 0, chip-select is active from the first setup cycle through the last hold cycle of each access and inactive during turnaround.
- R9: Ready is high when idle and in the last hold cycle of a word. A request waiting there is taken at once, so its first cycle follows the previous hold directly.
- R10: During reset, chip-select, output-enable and write-enable are inactive (high), the data bus is released, ready is high and response valid is low.
- R11: The address and data-out lines stay unchanged throughout each strobe phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data word |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Read data word |
| cfgBus16 | input | 1 | 1 = 16-bit external bus, 0 = 32-bit |
| cfgStrobeSel | input | 1 | 1 = chip-select active only in strobe phase |
| cfgRdSetup | input | TIME_W | Read setup length minus one |
| cfgRdStrobe | input | TIME_W | Read strobe length minus one |
| cfgRdHold | input | TIME_W | Read hold length minus one |
| cfgWrSetup | input | TIME_W | Write setup length minus one |
| cfgWrStrobe | input | TIME_W | Write strobe length minus one |
| cfgWrHold | input | TIME_W | Write hold length minus one |
| cfgTurn | input | TURN_W | Direction-change gap length minus one |
| memAddr | output | ADDR_W+1 | External address; LSB is the halfword select |
| memDataOut | output | DATA_W | External write data |
| memDataIn | input | DATA_W | External read data |
| memDataOe | output | 1 | Drive enable for the external data bus |
| memCsN | output | 1 | Chip-select, active low |
| memOeN | output | 1 | Output-enable, active low |
| memWeN | output | 1 | Write-enable, active low |

## Verification
The bench sweeps read and write phase fields, the turnaround field, both bus sizes and both chip-select modes. Each configuration runs the fixed direction pattern read, read, write, write, read, write, issued back to back, and every strobe start and length is predicted arithmetically. Giving the read and write fields different values makes a controller that borrows one direction's timing for the other miss its predicted strobe positions. The same-direction pairs and the direction changes tell a missing gap apart from a spurious one. The modelled bus returns valid data only on the last strobe cycle and drives junk on the unused upper lines in 16-bit mode, so sampling on the wrong cycle or from the wrong lane corrupts the assembled word.

// File: rtl/asc_pkg.sv
package asc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TURN,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic latchReq;   // capture a new request this cycle
    logic writeOp;    // direction of the access in flight
    logic upperHalf;  // second halfword of a 16-bit word
    logic busy;       // setup, strobe or hold phase
    logic rdStrobe;   // read strobe phase
    logic wrStrobe;   // write strobe phase
    logic capture;    // last read strobe cycle: sample the bus
    logic finish;     // last hold cycle of a word
  } ctrl_strobe_t;

endpackage

// File: rtl/asc_ctrl.sv
module asc_ctrl
  import asc_pkg::*;
#(
  parameter int TIME_W = 4,
  parameter int TURN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              cfgBus16,
  input  logic [TIME_W-1:0] cfgRdSetup,
  input  logic [TIME_W-1:0] cfgRdStrobe,
  input  logic [TIME_W-1:0] cfgRdHold,
  input  logic [TIME_W-1:0] cfgWrSetup,
  input  logic [TIME_W-1:0] cfgWrStrobe,
  input  logic [TIME_W-1:0] cfgWrHold,
  input  logic [TURN_W-1:0] cfgTurn,
  output logic              reqReady,
  output ctrl_strobe_t      ctl
);

  localparam int CNT_W = (TIME_W > TURN_W) ? TIME_W : TURN_W;

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  logic             opWrite;
  logic             upper;
  logic             seenAccess;

  logic [TIME_W-1:0] setupLen, strobeLen, holdLen, newSetup;
  logic phaseDone, lastHold, accept, needTurn;

  always_comb begin
    setupLen  = opWrite  ? cfgWrSetup  : cfgRdSetup;
    strobeLen = opWrite  ? cfgWrStrobe : cfgRdStrobe;
    holdLen   = opWrite  ? cfgWrHold   : cfgRdHold;
    newSetup  = reqWrite ? cfgWrSetup  : cfgRdSetup;
  end

  assign phaseDone = (cnt == '0);
  assign lastHold  = (phase == PH_HOLD) && phaseDone && (!cfgBus16 || upper);
  assign reqReady  = (phase == PH_IDLE) || lastHold;
  assign accept    = reqValid && reqReady;
  assign needTurn  = seenAccess && (reqWrite != opWrite);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      opWrite    <= 1'b0;
      upper      <= 1'b0;
      seenAccess <= 1'b0;
    end else if (accept) begin
      opWrite    <= reqWrite;
      seenAccess <= 1'b1;
      upper      <= 1'b0;
      if (needTurn) begin
        phase <= PH_TURN;
        cnt   <= CNT_W'(cfgTurn);
      end else begin
        phase <= PH_SETUP;
        cnt   <= CNT_W'(newSetup);
      end
    end else begin
      case (phase)
        PH_TURN: begin
          if (phaseDone) begin
            phase <= PH_SETUP;
            cnt   <= CNT_W'(setupLen);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_SETUP: begin
          if (phaseDone) begin
            phase <= PH_STROBE;
            cnt   <= CNT_W'(strobeLen);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_STROBE: begin
          if (phaseDone) begin
            phase <= PH_HOLD;
            cnt   <= CNT_W'(holdLen);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (phaseDone) begin
            if (cfgBus16 && !upper) begin
              upper <= 1'b1;
              phase <= PH_SETUP;
              cnt   <= CNT_W'(setupLen);
            end else begin
              phase <= PH_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl           = '0;
    ctl.latchReq  = accept;
    ctl.writeOp   = opWrite;
    ctl.upperHalf = upper;
    ctl.busy      = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    ctl.rdStrobe  = (phase == PH_STROBE) && !opWrite;
    ctl.wrStrobe  = (phase == PH_STROBE) && opWrite;
    ctl.capture   = (phase == PH_STROBE) && !opWrite && phaseDone;
    ctl.finish    = lastHold;
  end

endmodule

// File: rtl/asc_datapath.sv
module asc_datapath
  import asc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      ctl,
  input  logic              cfgBus16,
  input  logic              cfgStrobeSel,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W:0]   memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              rspQ;
  logic              halfSel;

  assign halfSel = cfgBus16 && ctl.upperHalf;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      rspQ <= ctl.finish;
      if (ctl.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.capture) begin
        if (!cfgBus16) begin
          rdataQ <= memDataIn;
        end else if (ctl.upperHalf) begin
          rdataQ[DATA_W-1:HALF_W] <= memDataIn[HALF_W-1:0];
        end else begin
          rdataQ[HALF_W-1:0] <= memDataIn[HALF_W-1:0];
        end
      end
    end
  end

  always_comb begin
    memAddr = {addrQ, halfSel};
    if (!cfgBus16) begin
      memDataOut = wdataQ;
    end else if (ctl.upperHalf) begin
      memDataOut = {{HALF_W{1'b0}}, wdataQ[DATA_W-1:HALF_W]};
    end else begin
      memDataOut = {{HALF_W{1'b0}}, wdataQ[HALF_W-1:0]};
    end
    memDataOe = ctl.busy && ctl.writeOp;
    memOeN    = !ctl.rdStrobe;
    memWeN    = !ctl.wrStrobe;
    memCsN    = cfgStrobeSel ? !(ctl.rdStrobe || ctl.wrStrobe) : !ctl.busy;
  end

  assign rspValid = rspQ;
  assign rspRdata = rdataQ;

endmodule

// File: rtl/async_strobe_ctrl.sv
module async_strobe_ctrl
  import asc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32,
  parameter int TIME_W = 4,
  parameter int TURN_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  input  logic              cfgBus16,
  input  logic              cfgStrobeSel,
  input  logic [TIME_W-1:0] cfgRdSetup,
  input  logic [TIME_W-1:0] cfgRdStrobe,
  input  logic [TIME_W-1:0] cfgRdHold,
  input  logic [TIME_W-1:0] cfgWrSetup,
  input  logic [TIME_W-1:0] cfgWrStrobe,
  input  logic [TIME_W-1:0] cfgWrHold,
  input  logic [TURN_W-1:0] cfgTurn,
  output logic [ADDR_W:0]   memAddr,
  output logic [DATA_W-1:0] memDataOut,
  input  logic [DATA_W-1:0] memDataIn,
  output logic              memDataOe,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN
);

  ctrl_strobe_t ctl;

  asc_ctrl #(
    .TIME_W(TIME_W),
    .TURN_W(TURN_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .cfgBus16   (cfgBus16),
    .cfgRdSetup (cfgRdSetup),
    .cfgRdStrobe(cfgRdStrobe),
    .cfgRdHold  (cfgRdHold),
    .cfgWrSetup (cfgWrSetup),
    .cfgWrStrobe(cfgWrStrobe),
    .cfgWrHold  (cfgWrHold),
    .cfgTurn    (cfgTurn),
    .reqReady   (reqReady),
    .ctl        (ctl)
  );

  asc_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cfgBus16    (cfgBus16),
    .cfgStrobeSel(cfgStrobeSel),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .memDataIn   (memDataIn),
    .memAddr     (memAddr),
    .memDataOut  (memDataOut),
    .memDataOe   (memDataOe),
    .memCsN      (memCsN),
    .memOeN      (memOeN),
    .memWeN      (memWeN),
    .rspValid    (rspValid),
    .rspRdata    (rspRdata)
  );

endmodule

// File: rtl/asc_checker.sv
module asc_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              cfgStrobeSel,
  input logic [ADDR_W:0]   memAddr,
  input logic [DATA_W-1:0] memDataOut,
  input logic              memDataOe,
  input logic              memCsN,
  input logic              memOeN,
  input logic              memWeN
);

  assert_enables_exclusive_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN));

  assert_write_drives_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDataOe);

  assert_read_releases_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDataOe);

  assert_cs_covers_strobe_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN || !memWeN) |-> !memCsN);

  assert_cs_strobe_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobeSel |-> (memCsN == (memOeN && memWeN)));

  assert_lines_stable_R11: assert property (@(posedge clk) disable iff (!rstN)
    ((!memOeN || !memWeN) && $past(!memOeN || !memWeN)) |-> ($stable(memAddr) && $stable(memDataOut)));

  assert_ready_no_strobe_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memOeN && memWeN));

  assert_rsp_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

bind async_strobe_ctrl asc_checker #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .rspValid    (rspValid),
  .cfgStrobeSel(cfgStrobeSel),
  .memAddr     (memAddr),
  .memDataOut  (memDataOut),
  .memDataOe   (memDataOe),
  .memCsN      (memCsN),
  .memOeN      (memOeN),
  .memWeN      (memWeN)
);

// File: tb/test_async_strobe_ctrl.sv
module test_async_strobe_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 32;
  localparam int HW = 16;
  localparam int TW = 4;
  localparam int NW = 4;
  localparam int NOPS = 6;
  localparam int MAXRUN = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspValid;
  logic [DW-1:0] rspRdata;
  logic cfgBus16 = 1'b0;
  logic cfgStrobeSel = 1'b0;
  logic [TW-1:0] cfgRdSetup = '0, cfgRdStrobe = '0, cfgRdHold = '0;
  logic [TW-1:0] cfgWrSetup = '0, cfgWrStrobe = '0, cfgWrHold = '0;
  logic [NW-1:0] cfgTurn = '0;
  logic [AW:0] memAddr;
  logic [DW-1:0] memDataOut;
  logic [DW-1:0] memDataIn;
  logic memDataOe, memCsN, memOeN, memWeN;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  async_strobe_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .TIME_W(TW), .TURN_W(NW)
  ) i_async_strobe_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata),
    .cfgBus16(cfgBus16), .cfgStrobeSel(cfgStrobeSel),
    .cfgRdSetup(cfgRdSetup), .cfgRdStrobe(cfgRdStrobe), .cfgRdHold(cfgRdHold),
    .cfgWrSetup(cfgWrSetup), .cfgWrStrobe(cfgWrStrobe), .cfgWrHold(cfgWrHold),
    .cfgTurn(cfgTurn), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataIn(memDataIn), .memDataOe(memDataOe), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN)
  );

  function automatic logic [HW-1:0] halfPat(input logic [AW:0] a);
    logic [AW:0] m;
    m = a * 21'd40503;
    return m[HW-1:0] ^ 16'h5A3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Pin monitor, sampled on the falling edge
  int cyc, runLen, nRuns, nAcc, nRsp, csCount;
  bit addrMoved;
  int runStart[MAXRUN];
  int runCnt[MAXRUN];
  bit runRead[MAXRUN];
  bit runOe[MAXRUN];
  logic [AW:0] runAddr[MAXRUN];
  logic [DW-1:0] runData[MAXRUN];
  int accCyc[NOPS];
  int rspCyc[NOPS];
  logic [DW-1:0] rspData[NOPS];

  always @(negedge clk) begin
    if (!rstN) begin
      cyc = 0; runLen = 0; nRuns = 0; nAcc = 0; nRsp = 0; csCount = 0; addrMoved = 0;
    end else begin
      cyc++;
      if (!memOeN || !memWeN) begin
        if (runLen == 0) begin
          if (nRuns < MAXRUN) begin
            runStart[nRuns] = cyc;
            runCnt[nRuns]   = 1;
            runRead[nRuns]  = !memOeN;
            runOe[nRuns]    = memDataOe;
            runAddr[nRuns]  = memAddr;
            runData[nRuns]  = memDataOut;
          end
          nRuns++;
        end else if (nRuns <= MAXRUN) begin
          runCnt[nRuns-1]++;
          if (memAddr != runAddr[nRuns-1] || memDataOut != runData[nRuns-1]) addrMoved = 1;
        end
        runLen++;
      end else begin
        runLen = 0;
      end
      if (!memCsN) csCount++;
      if (reqValid && reqReady && nAcc < NOPS) begin
        accCyc[nAcc] = cyc;
        nAcc++;
      end
      if (rspValid) begin
        if (nRsp < NOPS) begin
          rspCyc[nRsp]  = cyc;
          rspData[nRsp] = rspRdata;
        end
        nRsp++;
      end
    end
  end

  // External memory model: valid data only on the last read strobe cycle
  always_comb begin
    memDataIn = 32'hBAD0_BAD0;
    if (!memOeN && runLen == int'(cfgRdStrobe) + 1) begin
      if (cfgBus16) memDataIn = {16'hC3C3, halfPat(memAddr)};
      else memDataIn = {halfPat({memAddr[AW:1], 1'b1}), halfPat(memAddr)};
    end
  end

  bit opW[NOPS] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};

  task automatic runBatch(input int id, input int rs, input int rt, input int rh,
                          input int ws, input int wt, input int wh, input int ta,
                          input bit b16, input bit ssel);
    logic [AW-1:0] addr[NOPS];
    logic [DW-1:0] wdat[NOPS];
    int prevL, expCs, expRuns, k;
    rstN = 1'b0;
    cfgRdSetup = TW'(rs); cfgRdStrobe = TW'(rt); cfgRdHold = TW'(rh);
    cfgWrSetup = TW'(ws); cfgWrStrobe = TW'(wt); cfgWrHold = TW'(wh);
    cfgTurn = NW'(ta); cfgBus16 = b16; cfgStrobeSel = ssel;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
    for (int i = 0; i < NOPS; i++) begin
      addr[i] = AW'(id * 16 + i * 5 + 1);
      wdat[i] = 32'hA5C3_0000 ^ DW'(id << 4) ^ DW'(i * 32'h1357_9B0D);
      reqWrite = opW[i];
      reqAddr  = addr[i];
      reqWdata = wdat[i];
      reqValid = 1'b1;
      @(negedge clk);
      while (!reqReady) @(negedge clk);
      @(posedge clk);
      #1;
    end
    reqValid = 1'b0;
    for (int w = 0; w < 400 && nRsp < NOPS; w++) @(negedge clk);
    repeat (2) @(negedge clk);

    check(nAcc == NOPS, "R9", "accepted count", nAcc, NOPS);
    check(nRsp == NOPS, "R7", "response count", nRsp, NOPS);
    prevL = 0; expCs = 0; expRuns = 0; k = 0;
    for (int i = 0; i < NOPS && nAcc == NOPS; i++) begin
      int s, t, h, turn, halves, per, len;
      s = opW[i] ? ws : rs;
      t = opW[i] ? wt : rt;
      h = opW[i] ? wh : rh;
      turn = (i > 0 && opW[i] != opW[i-1]) ? ta + 1 : 0;
      halves = b16 ? 2 : 1;
      per = s + t + h + 3;
      len = turn + halves * per;
      if (i > 0) check(accCyc[i] == accCyc[i-1] + prevL, "R9", "back-to-back accept", accCyc[i], accCyc[i-1] + prevL);
      for (int hf = 0; hf < halves; hf++) begin
        int expStart;
        logic [DW-1:0] expData;
        expStart = accCyc[i] + turn + s + 2 + hf * per;
        if (k < MAXRUN && k < nRuns) begin
          if (hf == 1) check(runStart[k] == expStart, "R3", "second-half strobe start", runStart[k], expStart);
          else if (turn > 0) check(runStart[k] == expStart, "R5", "strobe start after turnaround", runStart[k], expStart);
          else check(runStart[k] == expStart, "R1", "strobe start after setup", runStart[k], expStart);
          check(runCnt[k] == t + 1, opW[i] ? "R4" : "R2", "strobe length", runCnt[k], t + 1);
          check(runRead[k] == !opW[i], "R2", "strobe type", runRead[k], !opW[i]);
          check(runAddr[k] == {addr[i], (b16 && hf == 1)}, "R6", "halfword address", runAddr[k], {addr[i], (b16 && hf == 1)});
          if (opW[i]) begin
            if (b16) expData = (hf == 1) ? {16'h0, wdat[i][31:16]} : {16'h0, wdat[i][15:0]};
            else expData = wdat[i];
            check(runData[k] == expData, "R6", "write data lanes", runData[k], expData);
            check(runOe[k] == 1'b1, "R2", "bus driven in write", runOe[k], 1);
          end else begin
            check(runOe[k] == 1'b0, "R2", "bus released in read", runOe[k], 0);
          end
        end
        k++;
      end
      if (i < nRsp) begin
        check(rspCyc[i] == accCyc[i] + len + 1, "R7", "response timing", rspCyc[i], accCyc[i] + len + 1);
        if (!opW[i]) check(rspData[i] == {halfPat({addr[i], 1'b1}), halfPat({addr[i], 1'b0})}, "R7",
                           "read word", rspData[i], {halfPat({addr[i], 1'b1}), halfPat({addr[i], 1'b0})});
      end
      expCs += ssel ? halves * (t + 1) : halves * per;
      expRuns += halves;
      prevL = len;
    end
    check(nRuns == expRuns, "R6", "strobe count", nRuns, expRuns);
    check(csCount == expCs, "R8", "chip-select cycles", csCount, expCs);
    check(addrMoved == 1'b0, "R11", "lines stable in strobe", addrMoved, 0);
  endtask

  initial begin
    int id;
    #(CLK_PERIOD * 2 + 1);
    check(memCsN && memOeN && memWeN, "R10", "strobes idle in reset", {memCsN, memOeN, memWeN}, 3'b111);
    check(!memDataOe, "R10", "bus released in reset", memDataOe, 0);
    check(reqReady && !rspValid, "R10", "ready/valid in reset", {reqReady, rspValid}, 2'b10);
    id = 0;
    for (int rs = 0; rs < 2; rs++)
      for (int rt = 0; rt < 3; rt++)
        for (int rh = 0; rh < 2; rh++)
          for (int ta = 0; ta < 3; ta++)
            for (int md = 0; md < 4; md++) begin
              runBatch(id, rs, rt, rh, 1 - rs, 3 - rt, 1 - rh, ta, md[0], md[1]);
              id++;
            end
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule